// File: doc/BRIEF.md
# Inverted Page Translation Unit

This block turns a 20-bit virtual word address into a physical core-store address by searching all physical page frames at once. Each frame owns one tag register that records which virtual block currently lives in it, plus a valid flag. The incoming address is split into a block number and a word offset. The block number is compared against every valid tag in the same cycle. A match yields the frame index joined to the unchanged offset. No match raises a fault that carries the missing block number, so that supervisory software can fetch the block from backing store.

The supervisor answers a fault by picking a frame, reloading that frame's tag through the write port, and then retrying the access. Any frame can be overwritten or invalidated at any time. If software ever leaves two valid frames holding the same block, the unit still answers with the lowest-numbered matching frame and raises a multiple-match error alongside the hit.

The response path is a small state machine with three named states. RSP_IDLE means no lookup was accepted in the previous cycle. RSP_HIT means the previous lookup matched. RSP_FAULT means it missed. The next state depends only on the current request: no request leads to RSP_IDLE, a request that matches leads to RSP_HIT, and a request that misses leads to RSP_FAULT. These transitions are the same from every state.

Top module: `inv_page_xlate`

## Requirements
- R1: After reset every frame is invalid and all response outputs are low. The first lookup after reset always faults.
- R2: The block number is `lk_vaddr[19:9]` and the word offset is `lk_vaddr[8:0]`. The physical address is `{frame_index[4:0], offset[8:0]}`, 14 bits wide. This holds at the extremes: block 2047 with offset 511, and block 0 with offset 0.
- R3: A lookup accepted at a clock edge whose block matches a valid frame drives `rsp_hit` high in the following cycle. In that cycle `rsp_paddr` carries the frame index and the offset.
- R4: A lookup that matches no valid frame drives `rsp_fault` high in the following cycle, with `rsp_fault_block` equal to the requested block number. `rsp_paddr` reads 0 during a fault, and `rsp_fault_block` reads 0 outside a fault.
- R5: `rsp_hit` and `rsp_fault` are never high together. Both are low in the cycle after an edge with no lookup.
- R6: A write with `wr_en` loads `wr_block` and `wr_valid` into frame `wr_frame`. Lookups from the next edge onward see the new contents. A lookup at the same edge as the write still sees the old contents.
- R7: When a frame is overwritten with a new block, lookups of its old block fault and lookups of its new block hit that frame.
- R8: A write with `wr_valid` low invalidates a frame. Later lookups of the block it held fault.
- R9: If several valid frames hold the requested block, the hit reports the lowest-numbered one and `rsp_multi` is high in the same cycle. `rsp_multi` is low whenever `rsp_hit` is low.
- R10: A frame loaded with a block while its valid flag is low never produces a hit for that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 20 | Virtual word address: block number in the upper 11 bits, offset in the lower 9 |
| wr_en | input | 1 | Frame tag write strobe |
| wr_frame | input | 5 | Index of the frame to write |
| wr_block | input | 11 | Block number to store in the frame |
| wr_valid | input | 1 | Valid flag to store in the frame |
| rsp_hit | output | 1 | Previous lookup matched |
| rsp_paddr | output | 14 | Physical address on a hit, otherwise 0 |
| rsp_fault | output | 1 | Previous lookup missed |
| rsp_fault_block | output | 11 | Missing block number on a fault, otherwise 0 |
| rsp_multi | output | 1 | More than one valid frame matched the hit |

## Verification
Every response is due exactly one cycle after the edge that accepts the lookup. A tag write changes the outcome only for lookups accepted at the edge after the one that stores it. The bench drives each request and write at a falling edge and forms its expectation from the model state before the write. It then applies the write to the model and samples the outputs one nanosecond after the next rising edge. Every output is compared in every cycle, so a result that comes early, late, or from the wrong side of a same-edge write shows up as a mismatch.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

    // Response state held between accepting a lookup and presenting its result
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/ipx_frame_regs.sv
module ipx_frame_regs #(
    parameter int FRAMES = 32,
    parameter int BLK_W  = 11,
    parameter int FIDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [FIDX_W-1:0]       wr_frame,
    input  logic [BLK_W-1:0]        wr_block,
    input  logic                    wr_valid,
    output logic [FRAMES-1:0]       valid_o,
    output logic [FRAMES*BLK_W-1:0] blk_o
);

    // One tag register and one valid flag per physical frame
    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        logic             sel;
        logic             v_q;
        logic [BLK_W-1:0] b_q;

        assign sel = wr_en && (wr_frame == FIDX_W'(f));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                b_q <= '0;
            end else if (sel) begin
                v_q <= wr_valid;
                b_q <= wr_block;
            end
        end

        assign valid_o[f]                = v_q;
        assign blk_o[f*BLK_W +: BLK_W]   = b_q;
    end

endmodule

// File: rtl/ipx_match.sv
module ipx_match #(
    parameter int FRAMES = 32,
    parameter int BLK_W  = 11,
    parameter int FIDX_W = 5
) (
    input  logic [BLK_W-1:0]        block_i,
    input  logic [FRAMES-1:0]       valid_i,
    input  logic [FRAMES*BLK_W-1:0] blk_i,
    output logic                    any_o,
    output logic                    multi_o,
    output logic [FIDX_W-1:0]       idx_o
);

    logic [FRAMES-1:0] match;

    // Parallel comparison against every frame tag
    for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
        assign match[f] = valid_i[f] && (blk_i[f*BLK_W +: BLK_W] == block_i);
    end

    // Lowest-numbered matching frame wins
    always_comb begin
        idx_o = '0;
        for (int i = FRAMES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = FIDX_W'(i);
        end
    end

    assign any_o   = |match;
    // Clearing the lowest set bit leaves something only if two or more are set
    assign multi_o = |(match & (match - FRAMES'(1)));

endmodule

// File: rtl/ipx_resp_fsm.sv
module ipx_resp_fsm
    import ipx_pkg::*;
#(
    parameter int BLK_W  = 11,
    parameter int OFS_W  = 9,
    parameter int FIDX_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic                     any_hit,
    input  logic                     multi,
    input  logic [FIDX_W-1:0]        hit_idx,
    input  logic [OFS_W-1:0]         offset,
    input  logic [BLK_W-1:0]         block,
    output logic                     rsp_hit,
    output logic [FIDX_W+OFS_W-1:0]  rsp_paddr,
    output logic                     rsp_fault,
    output logic [BLK_W-1:0]         rsp_fault_block,
    output logic                     rsp_multi
);

    rsp_state_e                state_q, state_d;
    logic [FIDX_W+OFS_W-1:0]   paddr_q;
    logic [BLK_W-1:0]          fblk_q;
    logic                      multi_q;

    // Transition: the request seen now decides the state presented next cycle
    always_comb begin
        unique case (state_q)
            RSP_IDLE, RSP_HIT, RSP_FAULT: begin
                if (!lk_valid)    state_d = RSP_IDLE;
                else if (any_hit) state_d = RSP_HIT;
                else              state_d = RSP_FAULT;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // Captured response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fblk_q  <= '0;
            multi_q <= 1'b0;
        end else if (lk_valid) begin
            paddr_q <= {hit_idx, offset};
            fblk_q  <= block;
            multi_q <= multi;
        end
    end

    // Outputs gated by state
    always_comb begin
        rsp_hit         = 1'b0;
        rsp_fault       = 1'b0;
        rsp_paddr       = '0;
        rsp_fault_block = '0;
        rsp_multi       = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_hit   = 1'b1;
                rsp_paddr = paddr_q;
                rsp_multi = multi_q;
            end
            RSP_FAULT: begin
                rsp_fault       = 1'b1;
                rsp_fault_block = fblk_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/inv_page_xlate.sv
module inv_page_xlate #(
    parameter int  VADDR_W = 20,
    parameter int  OFS_W   = 9,
    parameter int  FRAMES  = 32,
    localparam int BLK_W   = VADDR_W - OFS_W,
    localparam int FIDX_W  = $clog2(FRAMES),
    localparam int PADDR_W = FIDX_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VADDR_W-1:0] lk_vaddr,
    input  logic               wr_en,
    input  logic [FIDX_W-1:0]  wr_frame,
    input  logic [BLK_W-1:0]   wr_block,
    input  logic               wr_valid,
    output logic               rsp_hit,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic               rsp_fault,
    output logic [BLK_W-1:0]   rsp_fault_block,
    output logic               rsp_multi
);

    logic [BLK_W-1:0]        req_block;
    logic [OFS_W-1:0]        req_ofs;
    logic [FRAMES-1:0]       tag_valid;
    logic [FRAMES*BLK_W-1:0] tag_blk;
    logic                    m_any, m_multi;
    logic [FIDX_W-1:0]       m_idx;

    assign req_block = lk_vaddr[VADDR_W-1:OFS_W];
    assign req_ofs   = lk_vaddr[OFS_W-1:0];

    ipx_frame_regs #(.FRAMES(FRAMES), .BLK_W(BLK_W), .FIDX_W(FIDX_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .wr_block (wr_block),
        .wr_valid (wr_valid),
        .valid_o  (tag_valid),
        .blk_o    (tag_blk)
    );

    ipx_match #(.FRAMES(FRAMES), .BLK_W(BLK_W), .FIDX_W(FIDX_W)) match_i (
        .block_i (req_block),
        .valid_i (tag_valid),
        .blk_i   (tag_blk),
        .any_o   (m_any),
        .multi_o (m_multi),
        .idx_o   (m_idx)
    );

    ipx_resp_fsm #(.BLK_W(BLK_W), .OFS_W(OFS_W), .FIDX_W(FIDX_W)) fsm_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_valid        (lk_valid),
        .any_hit         (m_any),
        .multi           (m_multi),
        .hit_idx         (m_idx),
        .offset          (req_ofs),
        .block           (req_block),
        .rsp_hit         (rsp_hit),
        .rsp_paddr       (rsp_paddr),
        .rsp_fault       (rsp_fault),
        .rsp_fault_block (rsp_fault_block),
        .rsp_multi       (rsp_multi)
    );

endmodule

// File: rtl/ipx_checker.sv
module ipx_checker #(
    parameter int  VADDR_W = 20,
    parameter int  OFS_W   = 9,
    parameter int  FRAMES  = 32,
    localparam int BLK_W   = VADDR_W - OFS_W,
    localparam int FIDX_W  = $clog2(FRAMES),
    localparam int PADDR_W = FIDX_W + OFS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VADDR_W-1:0] lk_vaddr,
    input logic               rsp_hit,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic               rsp_fault,
    input logic [BLK_W-1:0]   rsp_fault_block,
    input logic               rsp_multi
);

    a_r5_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    a_r3_answer_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit || rsp_fault));

    a_r5_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_hit && !rsp_fault));

    a_r4_fault_block: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_fault || rsp_fault_block == $past(lk_vaddr[VADDR_W-1:OFS_W])));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

    a_r9_multi_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);

    a_r4_paddr_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

endmodule

bind inv_page_xlate ipx_checker #(.VADDR_W(VADDR_W), .OFS_W(OFS_W), .FRAMES(FRAMES)) chk_i (.*);

// File: tb/inv_page_xlate_tb_top.sv
`timescale 1ns/1ps
module inv_page_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [19:0] lk_vaddr;
    logic        wr_en;
    logic [4:0]  wr_frame;
    logic [10:0] wr_block;
    logic        wr_valid;
    logic        rsp_hit;
    logic [13:0] rsp_paddr;
    logic        rsp_fault;
    logic [10:0] rsp_fault_block;
    logic        rsp_multi;

    int total = 0;
    int bad   = 0;

    // Behavioural model of the frame tags
    logic [10:0] ref_blk [32];
    bit          ref_v   [32];

    always #2 clk = ~clk;

    inv_page_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .wr_en(wr_en), .wr_frame(wr_frame), .wr_block(wr_block), .wr_valid(wr_valid),
        .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_fault_block(rsp_fault_block), .rsp_multi(rsp_multi)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic lv, logic [10:0] blk, logic [8:0] ofs,
                        logic we, logic [4:0] wf, logic [10:0] wb, logic wv);
        int          cnt;
        logic [4:0]  e_idx;
        logic        e_hit, e_fault, e_multi;
        logic [13:0] e_paddr;
        logic [10:0] e_fb;
        @(negedge clk);
        lk_valid = lv;  lk_vaddr = {blk, ofs};
        wr_en = we;     wr_frame = wf;  wr_block = wb;  wr_valid = wv;
        cnt = 0;
        e_idx = '0;
        for (int f = 0; f < 32; f++) begin
            if (ref_v[f] && ref_blk[f] == blk) begin
                if (cnt == 0) e_idx = f[4:0];
                cnt++;
            end
        end
        e_hit   = lv && (cnt > 0);
        e_fault = lv && (cnt == 0);
        e_multi = e_hit && (cnt > 1);
        e_paddr = e_hit ? {e_idx, ofs} : 14'd0;
        e_fb    = e_fault ? blk : 11'd0;
        if (we) begin
            ref_blk[wf] = wb;
            ref_v[wf]   = wv;
        end
        @(posedge clk);
        #1;
        chk(tag, "hit",   32'(rsp_hit),         32'(e_hit));
        chk(tag, "fault", 32'(rsp_fault),       32'(e_fault));
        chk(tag, "paddr", 32'(rsp_paddr),       32'(e_paddr));
        chk(tag, "fblk",  32'(rsp_fault_block), 32'(e_fb));
        chk("R9", "multi", 32'(rsp_multi),      32'(e_multi));
    endtask

    task automatic wr(string tag, logic [4:0] f, logic [10:0] b, logic v);
        step(tag, 1'b0, 11'd0, 9'd0, 1'b1, f, b, v);
    endtask

    task automatic look(string tag, logic [10:0] b, logic [8:0] o);
        step(tag, 1'b1, b, o, 1'b0, 5'd0, 11'd0, 1'b0);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int f = 0; f < 32; f++) begin
            ref_blk[f] = '0;
            ref_v[f]   = 1'b0;
        end
        rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        wr_en = 1'b0; wr_frame = '0; wr_block = '0; wr_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset hit",   32'(rsp_hit),   32'd0);
        chk("R1", "reset fault", 32'(rsp_fault), 32'd0);
        chk("R1", "reset paddr", 32'(rsp_paddr), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        look("R1", 11'd100, 9'd5);
        step("R5", 1'b0, 11'd0, 9'd0, 1'b0, 5'd0, 11'd0, 1'b0);
        for (int f = 0; f < 8; f++) wr("R6", f[4:0], 11'(40 + 3 * f), 1'b1);
        look("R3", 11'd46, 9'd17);
        look("R3", 11'd40, 9'd300);
        look("R3", 11'd61, 9'd1);
        look("R4", 11'd999, 9'd77);
        // Same-edge write and lookup: old contents answer
        step("R6", 1'b1, 11'd500, 9'd1, 1'b1, 5'd9, 11'd500, 1'b1);
        look("R6", 11'd500, 9'd1);
        // Overwrite frame 2
        wr("R7", 5'd2, 11'd600, 1'b1);
        look("R7", 11'd46, 9'd3);
        look("R7", 11'd600, 9'd3);
        // Invalidate frame 3
        wr("R8", 5'd3, 11'd49, 1'b0);
        look("R8", 11'd49, 9'd8);
        // Loaded but not valid
        wr("R10", 5'd12, 11'd700, 1'b0);
        look("R10", 11'd700, 9'd8);
        // Duplicate tags
        wr("R9", 5'd20, 11'd43, 1'b1);
        look("R9", 11'd43, 9'd44);
        wr("R9", 5'd0, 11'd43, 1'b1);
        look("R9", 11'd43, 9'd45);
        wr("R9", 5'd0, 11'd43, 1'b0);
        wr("R9", 5'd1, 11'd43, 1'b0);
        look("R9", 11'd43, 9'd46);
        // Field extremes
        wr("R2", 5'd31, 11'd2047, 1'b1);
        look("R2", 11'd2047, 9'd511);
        wr("R2", 5'd30, 11'd0, 1'b1);
        look("R2", 11'd0, 9'd0);
        // Mixed traffic over a small block range
        for (int n = 0; n < 300; n++) begin
            step("R3", 1'($urandom_range(0, 1)), 11'($urandom_range(0, 15)),
                 9'($urandom_range(0, 511)), 1'($urandom_range(0, 1)),
                 5'($urandom_range(0, 31)), 11'($urandom_range(0, 15)),
                 1'($urandom_range(0, 3) != 0));
        end
        step("R5", 1'b0, 11'd0, 9'd0, 1'b0, 5'd0, 11'd0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule